// File: doc/BRIEF.md
# Byte Write Enable Decoder

This block converts the write-control inputs of a 36-bit memory port into registered per-lane write strobes. The word is split into four lanes of nine bits each: eight data bits and one parity bit. Three kinds of active-low input are sampled on each rising clock edge:

- a global write enable;
- a gate for the per-lane enables;
- one enable for each lane.

The global write has the higher priority. When it is asserted, every lane is written. Otherwise the per-lane enables pass through only while the gate is asserted. If neither path is active, the cycle is a read.

The block produces three outputs from the same sampled inputs, all registered together:

- an active-high strobe for each lane;
- a 36-bit per-bit write mask that the storage array can use directly;
- a flag telling output control to turn the data drivers off whenever any lane is written.

Top module: `byte_lane_strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `lane_wr` is 0, `bit_wr_mask` is 0 and `drv_off` is 0.
- R2: When `glob_wr_n` is 0 at an edge, `lane_wr` is all ones after that edge, whatever `lane_gate_n` and `lane_en_n` are.
- R3: When `glob_wr_n` is 1 and `lane_gate_n` is 0 at an edge, `lane_wr` equals the bitwise inverse of `lane_en_n` after that edge. Bit k of `lane_en_n` controls lane k.
- R4: When `glob_wr_n` is 1 and `lane_gate_n` is 1 at an edge, `lane_en_n` has no effect, and `lane_wr` is 0 after that edge.
- R5: `drv_off` is 1 exactly when at least one bit of `lane_wr` is 1, in the same cycle.
- R6: The outputs reflect the inputs sampled at the most recent rising edge and stay stable until the next edge. The latency is one cycle.
- R7: In `bit_wr_mask`, data bits 8k to 8k+7 and parity bit 32+k all equal `lane_wr[k]` for lane k = 0..3.
- R8: A cycle with no global write and no gated lane enable is a read. In that cycle `lane_wr` is 0, `drv_off` is 0 and `bit_wr_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| glob_wr_n | input | 1 | Global write, active low, writes all lanes |
| lane_gate_n | input | 1 | Active-low gate that lets `lane_en_n` through |
| lane_en_n | input | 4 | Active-low enable for each lane |
| lane_wr | output | 4 | Registered active-high lane write strobes |
| drv_off | output | 1 | Registered request to disable the data drivers |
| bit_wr_mask | output | 36 | Registered per-bit write mask, data bits 0..31 and parity bits 32..35 |

## Verification
Two functions can meet in one cycle: the global override and a gated per-lane mask. This happens when `glob_wr_n` and `lane_gate_n` are both low together with a partial lane pattern. The bench sweeps every lane pattern with both controls asserted, and then runs random control mixes. The expected result is a full write of all lanes, with the per-lane pattern ignored.

In the same cycles, the driver-off flag and the bit mask are compared against the lane strobes computed by the model.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    WK_READ   = 2'd0,
    WK_LANES  = 2'd1,
    WK_GLOBAL = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/bwd_lane_gate.sv
module bwd_lane_gate #(
  parameter int LANES = 4
) (
  input  logic             gate_n,
  input  logic [LANES-1:0] en_n,
  output logic [LANES-1:0] gated
);
  always_comb begin
    gated = gate_n ? '0 : ~en_n;
  end
endmodule

// File: rtl/bwd_priority.sv
module bwd_priority #(
  parameter int LANES = 4
) (
  input  logic              glob_n,
  input  logic [LANES-1:0]  gated,
  output logic [LANES-1:0]  lanes,
  output bwd_pkg::wr_kind_e kind
);
  import bwd_pkg::*;
  always_comb begin
    if (!glob_n) begin
      lanes = '1;
      kind  = WK_GLOBAL;
    end else if (|gated) begin
      lanes = gated;
      kind  = WK_LANES;
    end else begin
      lanes = '0;
      kind  = WK_READ;
    end
  end
endmodule

// File: rtl/bwd_bit_expand.sv
module bwd_bit_expand #(
  parameter int LANES     = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic [LANES-1:0]                 lanes,
  output logic [LANES*(BYTE_BITS+1)-1:0]   mask
);
  localparam int PAR_BASE = LANES * BYTE_BITS;
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar j = 0; j < BYTE_BITS; j++) begin : g_bit
      assign mask[k*BYTE_BITS + j] = lanes[k];
    end
    assign mask[PAR_BASE + k] = lanes[k];
  end
endmodule

// File: rtl/byte_lane_strobe_gen.sv
module byte_lane_strobe_gen #(
  parameter int LANES     = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            glob_wr_n,
  input  logic                            lane_gate_n,
  input  logic [LANES-1:0]                lane_en_n,
  output logic [LANES-1:0]                lane_wr,
  output logic                            drv_off,
  output logic [LANES*(BYTE_BITS+1)-1:0]  bit_wr_mask
);
  import bwd_pkg::*;
  localparam int WORD_W = LANES * (BYTE_BITS + 1);

  logic [LANES-1:0]  gated;
  logic [LANES-1:0]  lanes_d;
  wr_kind_e          kind_d;
  logic [WORD_W-1:0] mask_d;

  bwd_lane_gate #(.LANES(LANES)) u_gate (
    .gate_n (lane_gate_n),
    .en_n   (lane_en_n),
    .gated  (gated)
  );

  bwd_priority #(.LANES(LANES)) u_prio (
    .glob_n (glob_wr_n),
    .gated  (gated),
    .lanes  (lanes_d),
    .kind   (kind_d)
  );

  bwd_bit_expand #(.LANES(LANES), .BYTE_BITS(BYTE_BITS)) u_expand (
    .lanes (lanes_d),
    .mask  (mask_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_wr     <= '0;
      drv_off     <= 1'b0;
      bit_wr_mask <= '0;
    end else begin
      lane_wr     <= lanes_d;
      drv_off     <= (kind_d != WK_READ);
      bit_wr_mask <= mask_d;
    end
  end
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int LANES     = 4,
  parameter int BYTE_BITS = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            glob_wr_n,
  input logic                            lane_gate_n,
  input logic [LANES-1:0]                lane_en_n,
  input logic [LANES-1:0]                lane_wr,
  input logic                            drv_off,
  input logic [LANES*(BYTE_BITS+1)-1:0]  bit_wr_mask
);
  localparam int PAR_BASE = LANES * BYTE_BITS;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (lane_wr == '0 && !drv_off && bit_wr_mask == '0));

  a_r2_global_all: assert property (@(posedge clk) disable iff (rst)
    !glob_wr_n |=> (lane_wr == {LANES{1'b1}}));

  a_r3_gated_pass: assert property (@(posedge clk) disable iff (rst)
    (glob_wr_n && !lane_gate_n) |=> (lane_wr == ~$past(lane_en_n)));

  a_r4_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    (glob_wr_n && lane_gate_n) |=> (lane_wr == '0));

  a_r5_drv_off_any: assert property (@(posedge clk) disable iff (rst)
    drv_off == (|lane_wr));

  for (genvar k = 0; k < LANES; k++) begin : g_map
    a_r7_lane_map: assert property (@(posedge clk) disable iff (rst)
      (bit_wr_mask[k*BYTE_BITS +: BYTE_BITS] == {BYTE_BITS{lane_wr[k]}})
      && (bit_wr_mask[PAR_BASE + k] == lane_wr[k]));
  end
endmodule

bind byte_lane_strobe_gen bwd_checker #(.LANES(LANES), .BYTE_BITS(BYTE_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .glob_wr_n   (glob_wr_n),
  .lane_gate_n (lane_gate_n),
  .lane_en_n   (lane_en_n),
  .lane_wr     (lane_wr),
  .drv_off     (drv_off),
  .bit_wr_mask (bit_wr_mask)
);

// File: tb/byte_lane_strobe_gen_test.sv
module byte_lane_strobe_gen_test;
  localparam int LANES = 4;
  localparam int BB    = 8;
  localparam int W     = LANES * (BB + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             glob_wr_n = 1'b1;
  logic             lane_gate_n = 1'b1;
  logic [LANES-1:0] lane_en_n = '1;
  logic [LANES-1:0] lane_wr;
  logic             drv_off;
  logic [W-1:0]     bit_wr_mask;

  int tests = 0;
  int fails = 0;

  logic [LANES-1:0] exp_lanes = '0;
  string            exp_tag = "R1";

  byte_lane_strobe_gen #(.LANES(LANES), .BYTE_BITS(BB)) uut (
    .clk(clk), .rst(rst), .glob_wr_n(glob_wr_n), .lane_gate_n(lane_gate_n),
    .lane_en_n(lane_en_n), .lane_wr(lane_wr), .drv_off(drv_off),
    .bit_wr_mask(bit_wr_mask)
  );

  always #2 clk = ~clk;

  // Behavioural reference: written from R1..R4 and R8
  always @(posedge clk) begin
    if (rst) begin
      exp_lanes <= '0;
      exp_tag   <= "R1";
    end else if (glob_wr_n == 1'b0) begin
      exp_lanes <= '1;
      exp_tag   <= "R2";
    end else if (lane_gate_n == 1'b0) begin
      exp_lanes <= ~lane_en_n;
      exp_tag   <= (lane_en_n == '1) ? "R8" : "R3";
    end else begin
      exp_lanes <= '0;
      exp_tag   <= "R4";
    end
  end

  function automatic logic [W-1:0] exp_mask(input logic [LANES-1:0] l);
    logic [W-1:0] m;
    for (int b = 0; b < W; b++) begin
      if (b < LANES * BB) m[b] = l[b / BB];
      else                m[b] = l[b - LANES * BB];
    end
    return m;
  endfunction

  // Compare at the falling edge, half a cycle after the register update (R6)
  always @(negedge clk) begin
    tests++;
    if (lane_wr !== exp_lanes) begin
      fails++;
      $display("FAIL %s/R6 lane_wr act=%b exp=%b", exp_tag, lane_wr, exp_lanes);
    end
    tests++;
    if (drv_off !== (exp_lanes != '0)) begin
      fails++;
      $display("FAIL R5 drv_off act=%b exp=%b", drv_off, (exp_lanes != '0));
    end
    tests++;
    if (bit_wr_mask !== exp_mask(exp_lanes)) begin
      fails++;
      $display("FAIL R7 bit_wr_mask act=%h exp=%h", bit_wr_mask, exp_mask(exp_lanes));
    end
  end

  task automatic drive(input logic g, input logic gate, input logic [LANES-1:0] en);
    @(negedge clk);
    #1;
    glob_wr_n   = g;
    lane_gate_n = gate;
    lane_en_n   = en;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset with write controls asserted must still clear outputs
    drive(1'b0, 1'b0, 4'b0000);
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R2: global write alone and with every lane pattern
    for (int p = 0; p < 16; p++) drive(1'b0, 1'b1, p[3:0]);
    // R2 overriding gated mask in same cycle
    for (int p = 0; p < 16; p++) drive(1'b0, 1'b0, p[3:0]);
    // R3 / R8: gated lanes, every pattern
    for (int p = 0; p < 16; p++) drive(1'b1, 1'b0, p[3:0]);
    // R4: blocked lanes, every pattern
    for (int p = 0; p < 16; p++) drive(1'b1, 1'b1, p[3:0]);
    // R6: alternate write and read back to back
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 1'b0, 4'b1010);
      drive(1'b1, 1'b1, 4'b0000);
    end
    // random mixes, with one reset pulse mid-stream (R1)
    for (int i = 0; i < 300; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      drive(r[5], r[4], r[3:0]);
      if (i == 150) rst = 1'b1;
      if (i == 152) rst = 1'b0;
    end
    drive(1'b1, 1'b1, 4'b1111);
    repeat (2) @(negedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule